// File: doc/BRIEF.md
# LCD Segment Animation Engine

This block overlays a moving pattern on one group of eight LCD segments. Software loads two 8-bit pattern words, A and B, and a control word. Each pattern word has a working copy. A 16-step state counter moves the working copies through their sequence. A single-cycle frame event pulse advances the counter by one step. On each step, either A's copy or B's copy rotates left or right, as set by that word's shift code.

The two working copies are combined with AND or OR. The result is ORed into the static segment data of the selected group, either segments 0–7 or segments 8–15. The other group passes through unchanged. The output is combinational from registered state. It therefore shows the new pattern in the same cycle that follows the clock edge on which the event or write was taken.

The register port is a plain single-cycle write strobe with a combinational read mux. There is no valid/ready handshake: every access completes in one cycle and is never back-pressured. The event input and the segment lines are plain level signals sampled on each clock edge.

Top module: `lcd_anim_engine`

## Requirements
- R1: Reading address 0 (pattern A) or address 1 (pattern B) returns the value last written, even after the working copies have rotated.
- R2: Shift codes per pattern are 00 no shift, 01 rotate left (bit 7 re-enters at bit 0), 10 rotate right (bit 0 re-enters at bit 7), 11 no shift. Control word (address 2): bits [1:0] A code, [3:2] B code, bit 4 combine select, bit 5 group select.
- R3: On an event, A's copy rotates when the new state number is odd, and B's copy rotates when the new state number is even.
- R4: The state counter wraps from 15 to 0. After 16 events, both working copies are back at their loaded values.
- R5: Combine select 0 gives A AND B. Combine select 1 gives A OR B.
- R6: The animated group output is its segment data ORed with the combined pattern. The other group's output equals its segment data.
- R7: Group select 0 animates segments 0–7. Group select 1 animates segments 8–15.
- R8: The state changes only on a cycle with the event high. The state is read at address 3 in bits [3:0].
- R9: A write to address 0 or 1 clears the state to 0 and reloads that word's working copy. A write wins over an event in the same cycle, and no rotation takes place in that cycle.
- R10: Synchronous reset clears the state, both pattern words, both working copies and the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 A, 1 B, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 A, 1 B, 2 control, 3 state) |
| rd_data | output | 8 | Read data, combinational |
| frame_evt | input | 1 | Frame event pulse that advances the state |
| seg_in | input | 16 | Static segment data |
| seg_out | output | 16 | Segment data with animation applied |

## Verification
Writes and events are registered on one clock edge. Their effect on `seg_out` and on the readable state appears right after that edge. There is no further pipeline delay, and the read data follows the read address with zero cycles of latency. The bench drives every input on the falling edge. It then checks outputs on the next falling edge, which is exactly one rising edge after the stimulus. For each event, the bench steps its own model of the state and the rotated copies, and compares against that model at the same falling edge.

// File: rtl/lcd_anim_pkg.sv
package lcd_anim_pkg;
  localparam logic [1:0] ADDR_PAT_A = 2'd0;
  localparam logic [1:0] ADDR_PAT_B = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_RSVD  = 2'b11
  } shift_e;

  typedef struct packed {
    logic   grp_hi;
    logic   or_mode;
    shift_e b_shift;
    shift_e a_shift;
  } ctrl_t;
endpackage

// File: rtl/lcd_anim_regs.sv
module lcd_anim_regs
  import lcd_anim_pkg::*;
#(
  parameter int W      = 8,
  parameter int STATES = 16,
  localparam int SW    = $clog2(STATES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [1:0]    rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          frame_evt,
  output logic [W-1:0]  pat_a,
  output logic [W-1:0]  pat_b,
  output ctrl_t         ctrl,
  output logic [SW-1:0] state,
  output logic          load_a,
  output logic          load_b,
  output logic          step_a,
  output logic          step_b
);
  logic          advance;
  logic [SW-1:0] state_nx;

  assign load_a   = wr_en && (wr_addr == ADDR_PAT_A);
  assign load_b   = wr_en && (wr_addr == ADDR_PAT_B);
  assign advance  = frame_evt && !load_a && !load_b;
  assign state_nx = (state == SW'(STATES - 1)) ? '0 : state + 1'b1;
  assign step_a   = advance && state_nx[0];
  assign step_b   = advance && !state_nx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_a <= '0;
      pat_b <= '0;
      ctrl  <= '0;
      state <= '0;
    end else begin
      if (load_a) pat_a <= wr_data;
      if (load_b) pat_b <= wr_data;
      if (wr_en && wr_addr == ADDR_CTRL) ctrl <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
      if (load_a || load_b) state <= '0;
      else if (advance)     state <= state_nx;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_PAT_A: rd_data = pat_a;
      ADDR_PAT_B: rd_data = pat_b;
      ADDR_CTRL:  rd_data = W'(ctrl);
      default:    rd_data = W'(state);
    endcase
  end
endmodule

// File: rtl/lcd_anim_shifter.sv
module lcd_anim_shifter
  import lcd_anim_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  shift_e       mode,
  output logic [W-1:0] work
);
  always_ff @(posedge clk) begin
    if (rst)       work <= '0;
    else if (load) work <= load_val;
    else if (step) begin
      case (mode)
        SH_LEFT:  work <= {work[W-2:0], work[W-1]};
        SH_RIGHT: work <= {work[0], work[W-1:1]};
        default:  work <= work;
      endcase
    end
  end
endmodule

// File: rtl/lcd_anim_combine.sv
module lcd_anim_combine #(
  parameter int W = 8,
  localparam int GROUPS = 2
) (
  input  logic [W-1:0]        work_a,
  input  logic [W-1:0]        work_b,
  input  logic                or_mode,
  input  logic                grp_hi,
  input  logic [GROUPS*W-1:0] seg_in,
  output logic [GROUPS*W-1:0] seg_out
);
  logic [W-1:0] anim;
  assign anim = or_mode ? (work_a | work_b) : (work_a & work_b);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign seg_out[g*W +: W] = seg_in[g*W +: W] |
                               ((grp_hi == 1'(g)) ? anim : '0);
  end
endmodule

// File: rtl/lcd_anim_engine.sv
module lcd_anim_engine
  import lcd_anim_pkg::*;
#(
  parameter int W      = 8,
  parameter int STATES = 16,
  localparam int SW    = $clog2(STATES),
  localparam int SEGS  = 2 * W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [1:0]      rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic            frame_evt,
  input  logic [SEGS-1:0] seg_in,
  output logic [SEGS-1:0] seg_out
);
  logic [W-1:0]  pat_a, pat_b, work_a, work_b;
  ctrl_t         ctrl;
  logic [SW-1:0] state;
  logic          load_a, load_b, step_a, step_b;

  lcd_anim_regs #(.W(W), .STATES(STATES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_evt(frame_evt),
    .pat_a(pat_a), .pat_b(pat_b), .ctrl(ctrl), .state(state),
    .load_a(load_a), .load_b(load_b), .step_a(step_a), .step_b(step_b)
  );

  lcd_anim_shifter #(.W(W)) u_shift_a (
    .clk(clk), .rst(rst), .load(load_a), .load_val(wr_data),
    .step(step_a), .mode(ctrl.a_shift), .work(work_a)
  );

  lcd_anim_shifter #(.W(W)) u_shift_b (
    .clk(clk), .rst(rst), .load(load_b), .load_val(wr_data),
    .step(step_b), .mode(ctrl.b_shift), .work(work_b)
  );

  lcd_anim_combine #(.W(W)) u_comb (
    .work_a(work_a), .work_b(work_b), .or_mode(ctrl.or_mode),
    .grp_hi(ctrl.grp_hi), .seg_in(seg_in), .seg_out(seg_out)
  );
endmodule

// File: rtl/lcd_anim_checker.sv
module lcd_anim_checker #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_evt,
  input logic          load_a,
  input logic          load_b,
  input logic [SW-1:0] state,
  input logic [W-1:0]  work_a,
  input logic [W-1:0]  work_b,
  input logic [2*W-1:0] seg_in,
  input logic [2*W-1:0] seg_out
);
  a_r8_hold_without_event: assert property (@(posedge clk) disable iff (rst)
    (!frame_evt && !load_a && !load_b) |=> $stable(state));

  a_r9_write_clears: assert property (@(posedge clk) disable iff (rst)
    (load_a || load_b) |=> (state == '0));

  a_r4_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && !load_a && !load_b) |=> (state == SW'($past(state) + 1'b1)));

  a_r3_a_idle_on_even: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && !load_a && !load_b && state[0]) |=> $stable(work_a));

  a_r3_b_idle_on_odd: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && !load_a && !load_b && !state[0]) |=> $stable(work_b));

  a_r6_seg_kept: assert property (@(posedge clk) disable iff (rst)
    ((seg_out & seg_in) == seg_in));
endmodule

bind lcd_anim_engine lcd_anim_checker #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .frame_evt(frame_evt), .load_a(load_a), .load_b(load_b),
  .state(state), .work_a(work_a), .work_b(work_b), .seg_in(seg_in), .seg_out(seg_out)
);

// File: tb/tb_lcd_anim_engine.sv
module tb_lcd_anim_engine;
  logic        clk = 0, rst = 1, wr_en = 0, frame_evt = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [7:0]  wr_data = 0, rd_data;
  logic [15:0] seg_in = 0, seg_out;
  int checks = 0, fails = 0;
  bit done = 0;

  lcd_anim_engine dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rol(logic [7:0] v); return {v[6:0], v[7]}; endfunction
  function automatic logic [7:0] ror(logic [7:0] v); return {v[0], v[7:1]}; endfunction
  function automatic logic [7:0] rot(logic [7:0] v, logic [1:0] c);
    return (c == 2'b01) ? rol(v) : (c == 2'b10) ? ror(v) : v;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic evt();
    @(negedge clk); frame_evt = 1;
    @(negedge clk); frame_evt = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  // ctrl = {grp, or, bcode, acode}
  function automatic logic [7:0] cw(bit grp, bit orm, logic [1:0] bc, logic [1:0] ac);
    return {2'b00, grp, orm, bc, ac};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    seg_in = 16'h1234;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin rd(2'(i), d); chk("R10 reg", 16'(d), 16'h0); end
    chk("R10 seg", seg_out, 16'h1234);
  endtask

  task automatic t_left_a();
    logic [7:0] d;
    seg_in = 0;
    wr(2, cw(0, 1, 2'b00, 2'b01)); wr(1, 8'h00); wr(0, 8'h81);
    evt();
    chk("R3 A rotl on state 1", seg_out, 16'h0003);
    rd(3, d); chk("R8 state 1", 16'(d), 16'h1);
    evt();
    chk("R3 A held on state 2", seg_out, 16'h0003);
    rd(0, d); chk("R1 A readback", 16'(d), 16'h81);
  endtask

  task automatic t_right_b();
    logic [7:0] d;
    wr(2, cw(0, 1, 2'b10, 2'b00)); wr(0, 8'h00); wr(1, 8'h01);
    evt(); chk("R3 B held on state 1", seg_out, 16'h0001);
    evt(); chk("R2 B rotr on state 2", seg_out, 16'h0080);
    rd(1, d); chk("R1 B readback", 16'(d), 16'h01);
  endtask

  task automatic t_wrap();
    logic [7:0] ea = 8'h01, eb = 8'h80, d;
    logic [3:0] st = 0;
    wr(2, cw(0, 1, 2'b10, 2'b01)); wr(0, ea); wr(1, eb);
    for (int i = 0; i < 16; i++) begin
      evt(); st++;
      if (st[0]) ea = rot(ea, 2'b01); else eb = rot(eb, 2'b10);
      chk("R4 step pattern", seg_out, {8'h00, ea | eb});
      rd(3, d); chk("R4 step state", 16'(d), 16'(st));
    end
    chk("R4 wrapped pattern", seg_out, 16'h0081);
  endtask

  task automatic t_reserved();
    wr(2, cw(0, 1, 2'b11, 2'b11)); wr(0, 8'h5A); wr(1, 8'h00);
    repeat (4) evt();
    chk("R2 code 11 no shift", seg_out, 16'h005A);
  endtask

  task automatic t_logic();
    wr(2, cw(0, 0, 2'b00, 2'b00)); wr(0, 8'hF0); wr(1, 8'h3C);
    chk("R5 AND", seg_out, 16'h0030);
    wr(2, cw(0, 1, 2'b00, 2'b00));
    chk("R5 OR", seg_out, 16'h00FC);
  endtask

  task automatic t_group();
    wr(2, cw(1, 1, 2'b00, 2'b00)); wr(0, 8'hF0); wr(1, 8'h00);
    seg_in = 16'h0102;
    @(negedge clk);
    chk("R7 R6 high group", seg_out, 16'hF102);
    wr(2, cw(0, 1, 2'b00, 2'b00));
    chk("R7 R6 low group", seg_out, 16'h01F2);
    seg_in = 0;
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(2, cw(0, 1, 2'b00, 2'b01)); wr(1, 8'h00); wr(0, 8'h01);
    repeat (3) evt();
    repeat (5) @(negedge clk);
    rd(3, d); chk("R8 no event holds", 16'(d), 16'h3);
    chk("R8 pattern held", seg_out, 16'h0004);
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 8'h00; frame_evt = 1;
    @(negedge clk); wr_en = 0; frame_evt = 0;
    rd(3, d); chk("R9 write beats event", 16'(d), 16'h0);
    chk("R9 A copy not rotated", seg_out, 16'h0004);
    wr(0, 8'h10);
    chk("R9 A reload", seg_out, 16'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_left_a(); t_right_b(); t_wrap(); t_reserved();
    t_logic(); t_group(); t_clear();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule